// File: doc/BRIEF.md
# Display Power and Enable Sequencer

This block drives the power-up, power-down, display-enable and display-disable procedures of a small panel controller. Each procedure is an ordered list of 16-bit register writes, with stabilisation pauses between stages. The block presents each write as an address/value pair to a downstream serializer and holds it until the serializer accepts it. Pauses are counted on a 1 ms tick input. A frame pause counts `FRAME_COUNT` frames of `FRAME_MS` ticks each, 40 ticks by default.

The block also stores a 5-bit contrast level and a reverse (inversion) bit. It merges them into the supply and display-control writes that carry them. A change of either value is forwarded to the controller only when the controller is in a state where the value is live. A request that asks for a state already reached finishes at once and issues no writes. Commands arrive as a one-cycle `cmd_valid` strobe with an opcode. They are accepted only while `busy` is low. A single-cycle `done` pulse marks the end of each command.

Top module: `disp_pwr_seq`

## Requirements
- R1: Opcode 0 (power up) issues these writes as address=value, in this order: 03=0000, 00=0001, a wait of at least 10 ticks, 0C=0001, 0D=0401, 04=8000, 0E=0018|C, 03=002C, 0E=2018|C, a wait of at least 40 ticks, 0D=0411, a wait of at least 40 ticks, then nineteen fixed mode and gamma writes, then a wait of at least 100 ticks. The fixed writes go in ascending address order: 01=0113, 02=0700, 05=1028, 06=0000, 0B=4000, 11=0000, 14=9F00, 15=5C00, 16=7F00, 30=0003, 31=0400, 32=0407, 33=0305, 34=0003, 35=0704, 36=0407, 37=0503, 3A=1409, 3B=0602. Here C is the stored contrast shifted to bits 12:8. The default contrast is 19.
- R2: Opcode 2 (display on) writes register 07 with 0001, waits at least 40 ticks, writes 0021|V and then 0023|V, waits at least 40 ticks, and writes 0033|V. V is 0004 when the display is not inverted and 0000 when it is inverted. The reset state is not inverted.
- R3: Opcode 3 (display off) writes register 07 with 0032|V, waits at least 40 ticks, writes 0022|V, waits at least 40 ticks, and then writes 0000.
- R4: Opcode 1 (power down) writes 03=062C, 0D=0401 and 0E=0018|C, waits at least 100 ticks, and then writes 03=0000. If the display is on, the display-off writes of R3 are issued first. A display-on request while powered down runs the full R1 sequence first and then R2.
- R5: Power up while powered, power down while powered down, display on while on, display off while off, and opcode 7 all raise `done` in the cycle after the command is sampled. None of them issues a write.
- R6: Opcode 5 stores `invert_in` as the reverse state. If the state changed and the display is on, the block writes 07=0033|V. If the state is unchanged or the display is off, it issues no write.
- R7: Opcode 4 stores `contrast_in`, with 15 clamped to 14 and 31 clamped to 30. If the value changed and power is up, the block writes 0E=2018|C. Otherwise it issues no write.
- R8: Opcode 6 (standby) writes 03=0001 in any state and leaves the status flags unchanged.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values. Each pair is issued exactly once, on the cycle `wr_ready` is high.
- R10: A command strobed while `busy` is high is ignored and changes no stored setting.
- R11: `power_on` rises at the end of R1 and falls at the end of R4. `display_on` rises at the end of R2 and falls at the end of R3. `done` pulses for one cycle after the last write or wait of a command, with `busy` low. No write is offered while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 power up, 1 power down, 2 display on, 3 display off, 4 contrast, 5 invert, 6 standby |
| contrast_in | input | 5 | Contrast level for opcode 4 |
| invert_in | input | 1 | Invert flag for opcode 5 |
| wr_ready | input | 1 | Serializer accepts the offered pair |
| wr_valid | output | 1 | A register write is offered |
| wr_addr | output | 8 | Register address |
| wr_data | output | 16 | Register value |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A command sequence is running |
| power_on | output | 1 | Supplies are up |
| display_on | output | 1 | Display output is enabled |

## Verification
A command that needs no writes must raise `done` at the first falling edge after the clock edge that samples it. The bench checks `done` and `busy` at exactly that point. The first write of a sequence is offered from the cycle after the command is taken, and each later write waits on the serializer's `wr_ready`, which the bench stalls in a fixed pattern. Because write timing depends on those stalls, the scoreboard checks writes by order, not by cycle. It pops each expected pair on the falling edge where valid and ready are both high. For each pause it checks that the ticks counted between the two writes around the pause are at least the pause length. Flags and the empty queue are checked when `done` is seen.

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int unsigned OSC_MS       = 10,
  parameter int unsigned RAIL_MS      = 40,
  parameter int unsigned SETTLE_MS    = 100,
  parameter int unsigned FRAME_MS     = 20,
  parameter int unsigned FRAME_COUNT  = 2,
  parameter int unsigned DEF_CONTRAST = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_ms,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [4:0]  contrast_in,
  input  logic        invert_in,
  input  logic        wr_ready,
  output logic        wr_valid,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        done,
  output logic        busy,
  output logic        power_on,
  output logic        display_on
);
  localparam logic [1:0] K_WR = 2'd0, K_WT = 2'd1, K_END = 2'd2;
  localparam logic [15:0] T_OSC = 16'(OSC_MS);
  localparam logic [15:0] T_RAIL = 16'(RAIL_MS);
  localparam logic [15:0] T_SET = 16'(SETTLE_MS);
  localparam logic [15:0] T_FR = 16'(FRAME_MS * FRAME_COUNT);
  localparam logic [5:0] IX_PON = 6'd0, IX_PON_END = 6'd32, IX_DON = 6'd33, IX_DON_END = 6'd39,
                         IX_DOFF = 6'd40, IX_DOFF_END = 6'd45, IX_POFF = 6'd46, IX_POFF_END = 6'd51,
                         IX_CON = 6'd52, IX_INV = 6'd54, IX_STB = 6'd56;

  function automatic logic [27:0] step(input logic [5:0] i);
    case (i)
      6'd0:  step = {K_WR, 2'b00, 8'h03, 16'h0000};
      6'd1:  step = {K_WR, 2'b00, 8'h00, 16'h0001};
      6'd2:  step = {K_WT, 2'b00, 8'h00, T_OSC};
      6'd3:  step = {K_WR, 2'b00, 8'h0C, 16'h0001};
      6'd4:  step = {K_WR, 2'b00, 8'h0D, 16'h0401};
      6'd5:  step = {K_WR, 2'b00, 8'h04, 16'h8000};
      6'd6:  step = {K_WR, 2'b10, 8'h0E, 16'h0018};
      6'd7:  step = {K_WR, 2'b00, 8'h03, 16'h002C};
      6'd8:  step = {K_WR, 2'b10, 8'h0E, 16'h2018};
      6'd9:  step = {K_WT, 2'b00, 8'h00, T_RAIL};
      6'd10: step = {K_WR, 2'b00, 8'h0D, 16'h0411};
      6'd11: step = {K_WT, 2'b00, 8'h00, T_RAIL};
      6'd12: step = {K_WR, 2'b00, 8'h01, 16'h0113};
      6'd13: step = {K_WR, 2'b00, 8'h02, 16'h0700};
      6'd14: step = {K_WR, 2'b00, 8'h05, 16'h1028};
      6'd15: step = {K_WR, 2'b00, 8'h06, 16'h0000};
      6'd16: step = {K_WR, 2'b00, 8'h0B, 16'h4000};
      6'd17: step = {K_WR, 2'b00, 8'h11, 16'h0000};
      6'd18: step = {K_WR, 2'b00, 8'h14, 16'h9F00};
      6'd19: step = {K_WR, 2'b00, 8'h15, 16'h5C00};
      6'd20: step = {K_WR, 2'b00, 8'h16, 16'h7F00};
      6'd21: step = {K_WR, 2'b00, 8'h30, 16'h0003};
      6'd22: step = {K_WR, 2'b00, 8'h31, 16'h0400};
      6'd23: step = {K_WR, 2'b00, 8'h32, 16'h0407};
      6'd24: step = {K_WR, 2'b00, 8'h33, 16'h0305};
      6'd25: step = {K_WR, 2'b00, 8'h34, 16'h0003};
      6'd26: step = {K_WR, 2'b00, 8'h35, 16'h0704};
      6'd27: step = {K_WR, 2'b00, 8'h36, 16'h0407};
      6'd28: step = {K_WR, 2'b00, 8'h37, 16'h0503};
      6'd29: step = {K_WR, 2'b00, 8'h3A, 16'h1409};
      6'd30: step = {K_WR, 2'b00, 8'h3B, 16'h0602};
      6'd31: step = {K_WT, 2'b00, 8'h00, T_SET};
      6'd33: step = {K_WR, 2'b00, 8'h07, 16'h0001};
      6'd34: step = {K_WT, 2'b00, 8'h00, T_FR};
      6'd35: step = {K_WR, 2'b01, 8'h07, 16'h0021};
      6'd36: step = {K_WR, 2'b01, 8'h07, 16'h0023};
      6'd37: step = {K_WT, 2'b00, 8'h00, T_FR};
      6'd38: step = {K_WR, 2'b01, 8'h07, 16'h0033};
      6'd40: step = {K_WR, 2'b01, 8'h07, 16'h0032};
      6'd41: step = {K_WT, 2'b00, 8'h00, T_FR};
      6'd42: step = {K_WR, 2'b01, 8'h07, 16'h0022};
      6'd43: step = {K_WT, 2'b00, 8'h00, T_FR};
      6'd44: step = {K_WR, 2'b00, 8'h07, 16'h0000};
      6'd46: step = {K_WR, 2'b00, 8'h03, 16'h062C};
      6'd47: step = {K_WR, 2'b00, 8'h0D, 16'h0401};
      6'd48: step = {K_WR, 2'b10, 8'h0E, 16'h0018};
      6'd49: step = {K_WT, 2'b00, 8'h00, T_SET};
      6'd50: step = {K_WR, 2'b00, 8'h03, 16'h0000};
      6'd52: step = {K_WR, 2'b10, 8'h0E, 16'h2018};
      6'd54: step = {K_WR, 2'b01, 8'h07, 16'h0033};
      6'd56: step = {K_WR, 2'b00, 8'h03, 16'h0001};
      default: step = {K_END, 2'b00, 8'h00, 16'h0000};
    endcase
  endfunction

  logic        busy_q, pend_v, rev_q, pwr_q, disp_q, done_q;
  logic [5:0]  idx, pend_idx;
  logic [15:0] cnt;
  logic [4:0]  con_q, con_new;
  logic [27:0] cur;
  logic [1:0]  kind;
  logic [15:0] val;

  assign cur     = step(idx);
  assign kind    = cur[27:26];
  assign val     = cur[15:0];
  assign con_new = (contrast_in == 5'd15) ? 5'd14 : (contrast_in == 5'd31) ? 5'd30 : contrast_in;

  assign wr_valid   = busy_q && (kind == K_WR);
  assign wr_addr    = cur[23:16];
  assign wr_data    = val | (cur[25] ? {3'b000, con_q, 8'h00} : 16'h0000)
                          | (cur[24] ? {13'd0, rev_q, 2'b00} : 16'h0000);
  assign done       = done_q;
  assign busy       = busy_q;
  assign power_on   = pwr_q;
  assign display_on = disp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; pend_v <= 1'b0; pend_idx <= '0; idx <= '0; cnt <= '0;
      rev_q <= 1'b1; pwr_q <= 1'b0; disp_q <= 1'b0; done_q <= 1'b0;
      con_q <= 5'(DEF_CONTRAST);
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          case (cmd_op)
            3'd0: if (pwr_q) done_q <= 1'b1; else begin busy_q <= 1'b1; idx <= IX_PON; end
            3'd1: if (!pwr_q) done_q <= 1'b1;
                  else if (disp_q) begin busy_q <= 1'b1; idx <= IX_DOFF; pend_v <= 1'b1; pend_idx <= IX_POFF; end
                  else begin busy_q <= 1'b1; idx <= IX_POFF; end
            3'd2: if (disp_q) done_q <= 1'b1;
                  else if (!pwr_q) begin busy_q <= 1'b1; idx <= IX_PON; pend_v <= 1'b1; pend_idx <= IX_DON; end
                  else begin busy_q <= 1'b1; idx <= IX_DON; end
            3'd3: if (!disp_q) done_q <= 1'b1; else begin busy_q <= 1'b1; idx <= IX_DOFF; end
            3'd4: begin
              con_q <= con_new;
              if (con_new != con_q && pwr_q) begin busy_q <= 1'b1; idx <= IX_CON; end
              else done_q <= 1'b1;
            end
            3'd5: begin
              rev_q <= !invert_in;
              if ((!invert_in) != rev_q && disp_q) begin busy_q <= 1'b1; idx <= IX_INV; end
              else done_q <= 1'b1;
            end
            3'd6: begin busy_q <= 1'b1; idx <= IX_STB; end
            default: done_q <= 1'b1;
          endcase
        end
      end else begin
        case (kind)
          K_WR: if (wr_ready) idx <= idx + 6'd1;
          K_WT: if (cnt == val) begin cnt <= '0; idx <= idx + 6'd1; end
                else if (tick_ms) cnt <= cnt + 16'd1;
          default: begin
            if (idx == IX_PON_END)  pwr_q  <= 1'b1;
            if (idx == IX_POFF_END) pwr_q  <= 1'b0;
            if (idx == IX_DON_END)  disp_q <= 1'b1;
            if (idx == IX_DOFF_END) disp_q <= 1'b0;
            if (pend_v) begin idx <= pend_idx; pend_v <= 1'b0; end
            else begin busy_q <= 1'b0; done_q <= 1'b1; end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [7:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        done,
  input logic        busy,
  input logic        power_on,
  input logic        display_on
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  a_r4_display_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    display_on |-> power_on);
  a_r5_match_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 3'd0 && power_on) |=> (done && !busy));
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);
  a_r11_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(power_on) && $stable(display_on)));
endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (.*);

// File: tb/disp_pwr_seq_test.sv
module disp_pwr_seq_test;
  logic clk = 0, rst_n = 0, tick_ms = 0, cmd_valid = 0, invert_in = 0, wr_ready = 0;
  logic [2:0] cmd_op = 0;
  logic [4:0] contrast_in = 0;
  logic wr_valid, done, busy, power_on, display_on;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;
  int checks = 0, errors = 0, ntick = 0, last_tick = 0, cyc = 0;
  bit finished = 0;
  logic [39:0] q[$];

  disp_pwr_seq uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    tick_ms = (cyc % 5 == 0);
    wr_ready = (cyc % 3 != 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic exp_w(input logic [7:0] a, input logic [15:0] d, input int gap);
    q.push_back({16'(gap), a, d});
  endtask

  always @(negedge clk) begin
    if (tick_ms) ntick++;
    if (rst_n && wr_valid && wr_ready) begin
      if (q.size() == 0) chk(0, "R9 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [39:0] e;
        e = q.pop_front();
        chk({wr_addr, wr_data} == e[23:0], "R1-order write pair", {wr_addr, wr_data}, e[23:0]);
        chk(ntick - last_tick >= int'(e[39:24]), "R2 pause length", ntick - last_tick, e[39:24]);
      end
      last_tick = ntick;
    end
  end

  task automatic push_pon(input logic [4:0] c);
    logic [15:0] cs;
    cs = {3'b0, c, 8'h00};
    exp_w(8'h03, 16'h0000, 0); exp_w(8'h00, 16'h0001, 0);
    exp_w(8'h0C, 16'h0001, 10); exp_w(8'h0D, 16'h0401, 0); exp_w(8'h04, 16'h8000, 0);
    exp_w(8'h0E, 16'h0018 | cs, 0); exp_w(8'h03, 16'h002C, 0); exp_w(8'h0E, 16'h2018 | cs, 0);
    exp_w(8'h0D, 16'h0411, 40);
    exp_w(8'h01, 16'h0113, 40); exp_w(8'h02, 16'h0700, 0); exp_w(8'h05, 16'h1028, 0);
    exp_w(8'h06, 16'h0000, 0); exp_w(8'h0B, 16'h4000, 0); exp_w(8'h11, 16'h0000, 0);
    exp_w(8'h14, 16'h9F00, 0); exp_w(8'h15, 16'h5C00, 0); exp_w(8'h16, 16'h7F00, 0);
    exp_w(8'h30, 16'h0003, 0); exp_w(8'h31, 16'h0400, 0); exp_w(8'h32, 16'h0407, 0);
    exp_w(8'h33, 16'h0305, 0); exp_w(8'h34, 16'h0003, 0); exp_w(8'h35, 16'h0704, 0);
    exp_w(8'h36, 16'h0407, 0); exp_w(8'h37, 16'h0503, 0); exp_w(8'h3A, 16'h1409, 0);
    exp_w(8'h3B, 16'h0602, 0);
  endtask

  task automatic push_don(input logic [15:0] v, input int g0);
    exp_w(8'h07, 16'h0001, g0); exp_w(8'h07, 16'h0021 | v, 40);
    exp_w(8'h07, 16'h0023 | v, 0); exp_w(8'h07, 16'h0033 | v, 40);
  endtask

  task automatic push_doff(input logic [15:0] v);
    exp_w(8'h07, 16'h0032 | v, 0); exp_w(8'h07, 16'h0022 | v, 40); exp_w(8'h07, 16'h0000, 40);
  endtask

  task automatic push_poff(input logic [4:0] c, input int g0);
    exp_w(8'h03, 16'h062C, g0); exp_w(8'h0D, 16'h0401, 0);
    exp_w(8'h0E, 16'h0018 | {3'b0, c, 8'h00}, 0); exp_w(8'h03, 16'h0000, 100);
  endtask

  task automatic fire(input logic [2:0] op, input logic [4:0] c, input logic inv);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = op; contrast_in = c; invert_in = inv;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, {tag, " done seen"}, done, 1);
    chk(q.size() == 0, {tag, " all writes issued"}, q.size(), 0);
  endtask

  task automatic immediate(input logic [2:0] op, input logic [4:0] c, input logic inv, input string tag);
    fire(op, c, inv);
    @(negedge clk);
    chk(done && !busy, {tag, " done next cycle"}, {done, busy}, 2'b10);
    chk(q.size() == 0, {tag, " no writes"}, q.size(), 0);
  endtask

  task automatic flags(input bit p, input bit d, input string tag);
    chk(power_on == p && display_on == d, {tag, " status flags"}, {power_on, display_on}, {p, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: R11 sequence hung actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid, "R11 reset outputs", {busy, done, wr_valid}, 0);
    flags(0, 0, "R11 reset");

    immediate(3'd3, 0, 0, "R5 display-off while off");
    immediate(3'd1, 0, 0, "R5 power-down while down");
    immediate(3'd7, 0, 0, "R5 unused opcode");

    push_pon(5'd19); push_don(16'h0004, 100);
    fire(3'd2, 0, 0); wait_done("R4 display-on chains R1 then R2");
    flags(1, 1, "R11 after display-on");

    immediate(3'd0, 0, 0, "R5 power-up while up");
    immediate(3'd2, 0, 0, "R5 display-on while on");

    exp_w(8'h07, 16'h0033, 0);
    fire(3'd5, 0, 1); wait_done("R6 invert while on");
    immediate(3'd5, 0, 1, "R6 unchanged invert");

    exp_w(8'h0E, 16'h2E18, 0);
    fire(3'd4, 5'd15, 0); wait_done("R7 clamp 15 to 14");
    exp_w(8'h0E, 16'h3E18, 0);
    fire(3'd4, 5'd31, 0); wait_done("R7 clamp 31 to 30");
    immediate(3'd4, 5'd30, 0, "R7 unchanged contrast");

    push_doff(16'h0000);
    fire(3'd3, 0, 0);
    repeat (20) @(posedge clk);
    chk(busy, "R10 busy during display-off", busy, 1);
    fire(3'd4, 5'd5, 0);
    wait_done("R3 display-off");
    flags(1, 0, "R11 after display-off");

    push_poff(5'd30, 0);
    fire(3'd1, 0, 0); wait_done("R10 contrast kept, R4 power-down");
    flags(0, 0, "R11 after power-down");

    immediate(3'd5, 0, 0, "R6 invert while display off");
    immediate(3'd4, 5'd3, 0, "R7 contrast while powered down");

    exp_w(8'h03, 16'h0001, 0);
    fire(3'd6, 0, 0); wait_done("R8 standby");
    flags(0, 0, "R8 standby flags");

    push_pon(5'd3); push_don(16'h0004, 100);
    fire(3'd2, 0, 0); wait_done("R4 second bring-up with stored settings");
    flags(1, 1, "R11 second bring-up");

    push_doff(16'h0004); push_poff(5'd3, 0);
    fire(3'd1, 0, 0); wait_done("R4 power-down with display on");
    flags(0, 0, "R4 final flags");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule